// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block is the control sequencer of a small non-pipelined 8-bit processor with one-byte opcodes. Each instruction passes through four fixed phases: decode/register-read, memory, ALU/PC-update, and fetch/register-write. One instruction finishes before the next begins, so an instruction always takes four clock cycles. The sequencer holds the program counter, drives a 16-bit address bus with a read strobe, and samples an 8-bit data bus. It also drives three address-space qualifier lines (code, I/O, system) that let a system split its memory into separate spaces.

The memory phase comes before the ALU phase. An opcode can therefore have a trailing operand byte, read from PC+1 during the memory phase and handed to the ALU phase on the operand output. A small stub decoder recognises the operand-carrying opcodes and four special load opcodes. Those loads read at an address supplied by the register file (`ptr_i`). Full decoding, the ALU and the register file lie outside the block.

Interrupts are taken only at an instruction boundary. The sequencer then fetches the next opcode from a fixed vector with the system qualifier raised and reports the address that was skipped.

Top module: `instr_phase_seq`

## Requirements
- R1: `phase_o` steps one value per clock in the repeating order decode (0), memory (1), ALU (2), fetch (3), then back to decode.
- R2: While `rst_ni` is low and in the first cycle after it rises, `phase_o` is fetch (3), `pc_o` and `addr_o` are 0x0000, and `sys_o` is low.
- R3: In every fetch phase, `rd_o` and `code_o` are high, `io_o` is low, and `addr_o` equals `pc_o` unless an interrupt is being entered. The byte on `data_i` is latched and shown on `opcode_o` from the next decode phase through the next fetch phase.
- R4: An opcode whose bits [7:6] are 2'b10 reads its operand in the memory phase with `rd_o` and `code_o` high and `addr_o` = PC+1. That byte appears on `operand_o` with `operand_valid_o` high during the ALU phase.
- R5: `pc_o` changes only at the end of an ALU phase and at interrupt entry. At the end of the ALU phase it adds 2 for a 2'b10-prefixed opcode and 1 otherwise, wrapping modulo 2^16.
- R6: Opcode 0x4C reads in the memory phase at `ptr_i` with `code_o` high. Opcode 0x4D reads there with `io_o` high. In both cases the byte read appears on `operand_o` with `operand_valid_o` in the ALU phase.
- R7: Opcode 0x4E reads in the memory phase at `ptr_i` with `sys_o` high. Opcode 0x4F reads there with no qualifier. In both cases the byte read appears on `operand_o` with `operand_valid_o` in the ALU phase.
- R8: Any other opcode makes no bus read in the memory phase and leaves `operand_valid_o` low in the ALU phase.
- R9: `irq_i` is sampled only in the ALU phase, and only when `irq_en_i` is high. When both are high, the next fetch reads `IRQ_VECTOR` with `code_o` and `sys_o` high, `pc_o` becomes `IRQ_VECTOR`, and `ret_pc_o` holds the program counter value whose fetch was skipped. At any other time `irq_i` has no effect.
- R10: `rd_o` is high only in fetch phases and in memory phases that read. A qualifier is high only while `rd_o` is high. At most one qualifier is high at a time, except that `code_o` and `sys_o` are both high in an interrupt-entry fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus read value |
| ptr_i | input | 16 | Load address from the register file, used by the special loads |
| irq_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Interrupt enable flag |
| addr_o | output | 16 | Address bus |
| rd_o | output | 1 | Read strobe, one cycle per access |
| code_o | output | 1 | Code-space qualifier |
| io_o | output | 1 | I/O-space qualifier |
| sys_o | output | 1 | System-space qualifier |
| phase_o | output | 2 | Current phase: 0 decode, 1 memory, 2 ALU, 3 fetch |
| pc_o | output | 16 | Program counter |
| opcode_o | output | 8 | Latched opcode |
| operand_o | output | 8 | Byte read in the memory phase |
| operand_valid_o | output | 1 | `operand_o` is valid (ALU phase only) |
| ret_pc_o | output | 16 | Address skipped by the last interrupt entry |

## Verification
The bench places an operand-carrying opcode at the interrupt vector 0xFFFE. Entering there forces the program counter through 0xFFFF to 0x0000: a design that carried past bit 15, or stepped by 1, would fetch from the wrong place. It toggles `irq_i` and `irq_en_i` in the decode, memory and fetch phases, and raises a request with the enable low. A sequencer that sampled outside the ALU phase, or ignored the enable, would show `sys_o` or the vector address in the next fetch. The bench runs opcodes with prefixes 01 and 11, next to the 10 prefix and each special load. A decoder that looked at the wrong bits would read a stray operand, raise the wrong qualifier, or step the counter by the wrong amount.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [1:0] {
        PH_DEC   = 2'd0,
        PH_MEM   = 2'd1,
        PH_ALU   = 2'd2,
        PH_FETCH = 2'd3
    } phase_e;

    // what the memory phase does for a given opcode
    typedef enum logic [2:0] {
        MK_NONE = 3'd0,
        MK_IMM  = 3'd1,
        MK_CODE = 3'd2,
        MK_IO   = 3'd3,
        MK_SYS  = 3'd4,
        MK_DATA = 3'd5
    } mem_kind_e;

    localparam logic [OPC_W-1:0] OPC_LD_CODE = 8'h4C;
    localparam logic [OPC_W-1:0] OPC_LD_IO   = 8'h4D;
    localparam logic [OPC_W-1:0] OPC_LD_SYS  = 8'h4E;
    localparam logic [OPC_W-1:0] OPC_LD_DATA = 8'h4F;
    localparam logic [1:0]       IMM_PREFIX  = 2'b10;

    typedef struct packed {
        mem_kind_e kind;
        logic      has_imm;
    } dec_t;

endpackage

// File: rtl/iseq_decode.sv
module iseq_decode
    import iseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output dec_t             dec_o
);

    always_comb begin
        dec_o.kind    = MK_NONE;
        dec_o.has_imm = 1'b0;
        if (opcode_i[OPC_W-1 -: 2] == IMM_PREFIX) begin
            dec_o.kind    = MK_IMM;
            dec_o.has_imm = 1'b1;
        end else begin
            unique case (opcode_i)
                OPC_LD_CODE: dec_o.kind = MK_CODE;
                OPC_LD_IO:   dec_o.kind = MK_IO;
                OPC_LD_SYS:  dec_o.kind = MK_SYS;
                OPC_LD_DATA: dec_o.kind = MK_DATA;
                default:     dec_o.kind = MK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/iseq_bus.sv
module iseq_bus
    import iseq_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR = '0
) (
    input  phase_e            phase_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  mem_kind_e         kind_i,
    input  logic              irq_entry_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic              code_o,
    output logic              io_o,
    output logic              sys_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        addr_o = pc_i;
        rd_o   = 1'b0;
        code_o = 1'b0;
        io_o   = 1'b0;
        sys_o  = 1'b0;
        unique case (phase_i)
            PH_FETCH: begin
                rd_o   = 1'b1;
                code_o = 1'b1;
                if (irq_entry_i) begin
                    addr_o = IRQ_VECTOR;
                    sys_o  = 1'b1;
                end
            end
            PH_MEM: begin
                unique case (kind_i)
                    MK_IMM: begin
                        rd_o   = 1'b1;
                        code_o = 1'b1;
                        addr_o = pc_i + ONE;
                    end
                    MK_CODE: begin
                        rd_o   = 1'b1;
                        code_o = 1'b1;
                        addr_o = ptr_i;
                    end
                    MK_IO: begin
                        rd_o   = 1'b1;
                        io_o   = 1'b1;
                        addr_o = ptr_i;
                    end
                    MK_SYS: begin
                        rd_o   = 1'b1;
                        sys_o  = 1'b1;
                        addr_o = ptr_i;
                    end
                    MK_DATA: begin
                        rd_o   = 1'b1;
                        addr_o = ptr_i;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/instr_phase_seq.sv
module instr_phase_seq
    import iseq_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR = ADDR_W'(16'h0038)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [OPC_W-1:0]  data_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              irq_i,
    input  logic              irq_en_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic              code_o,
    output logic              io_o,
    output logic              sys_o,
    output logic [1:0]        phase_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [OPC_W-1:0]  operand_o,
    output logic              operand_valid_o,
    output logic [ADDR_W-1:0] ret_pc_o
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] pc;
        logic [OPC_W-1:0]  ir;
        logic [OPC_W-1:0]  opnd;
        logic              opnd_vld;
        logic              entry;
        logic [ADDR_W-1:0] ret;
    } state_t;

    state_t s_d, s_q;
    dec_t   dec;
    logic   bus_rd;

    iseq_decode u_decode (
        .opcode_i (s_q.ir),
        .dec_o    (dec)
    );

    iseq_bus #(
        .ADDR_W     (ADDR_W),
        .IRQ_VECTOR (IRQ_VECTOR)
    ) u_bus (
        .phase_i     (s_q.phase),
        .pc_i        (s_q.pc),
        .ptr_i       (ptr_i),
        .kind_i      (dec.kind),
        .irq_entry_i (s_q.entry),
        .addr_o      (addr_o),
        .rd_o        (bus_rd),
        .code_o      (code_o),
        .io_o        (io_o),
        .sys_o       (sys_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_e'(s_q.phase + 2'd1);
        unique case (s_q.phase)
            PH_FETCH: begin
                s_d.ir = data_i;
                if (s_q.entry) begin
                    s_d.ret   = s_q.pc;
                    s_d.pc    = IRQ_VECTOR;
                    s_d.entry = 1'b0;
                end
            end
            PH_MEM: begin
                s_d.opnd_vld = bus_rd;
                if (bus_rd) begin
                    s_d.opnd = data_i;
                end
            end
            PH_ALU: begin
                s_d.opnd_vld = 1'b0;
                s_d.pc       = s_q.pc + (dec.has_imm ? STEP_TWO : STEP_ONE);
                s_d.entry    = irq_i & irq_en_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.phase    <= PH_FETCH;
            s_q.pc       <= '0;
            s_q.ir       <= '0;
            s_q.opnd     <= '0;
            s_q.opnd_vld <= 1'b0;
            s_q.entry    <= 1'b0;
            s_q.ret      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_o            = bus_rd;
    assign phase_o         = s_q.phase;
    assign pc_o            = s_q.pc;
    assign opcode_o        = s_q.ir;
    assign operand_o       = s_q.opnd;
    assign operand_valid_o = s_q.opnd_vld;
    assign ret_pc_o        = s_q.ret;

    // R1: phases advance one step per clock in fixed order
    p_phase_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> phase_o == $past(phase_o) + 2'd1);

    // R3: every fetch is a code-space read
    p_fetch_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_FETCH) |-> (rd_o && code_o && !io_o));

    // R5: program counter step at the end of the ALU phase
    p_pc_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_ALU) |=> pc_o == $past(pc_o) +
            (($past(opcode_o[OPC_W-1 -: 2]) == IMM_PREFIX) ? STEP_TWO : STEP_ONE));

    // R5: counter holds in decode and memory phases
    p_pc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_DEC || phase_o == PH_MEM) |=> $stable(pc_o));

    // R8: operand valid only in the ALU phase
    p_opnd_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        operand_valid_o |-> (phase_o == PH_ALU));

    // R9: a taken request leads to a system fetch at the vector
    p_irq_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_ALU && irq_i && irq_en_i) |=> (sys_o && addr_o == IRQ_VECTOR));

    // R9: no request, no system fetch
    p_irq_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_ALU && !(irq_i && irq_en_i)) |=> !sys_o);

    // R9: the entry fetch loads the vector into the counter
    p_irq_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_FETCH && sys_o) |=> (pc_o == IRQ_VECTOR && ret_pc_o == $past(pc_o)));

    // R10: a qualifier needs the strobe
    p_qual_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_o || io_o || sys_o) |-> rd_o);

    // R10: one qualifier, except code with system on an entry fetch
    p_one_qual_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(phase_o == PH_FETCH && sys_o) |-> $onehot0({code_o, io_o, sys_o}));

    // R10: no strobe in decode and ALU phases
    p_rd_phase_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_DEC || phase_o == PH_ALU) |-> !rd_o);

endmodule

// File: tb/instr_phase_seq_tb_top.sv
module instr_phase_seq_tb_top;

    localparam int           CLK_PERIOD = 10;
    localparam logic [15:0]  VEC        = 16'hFFFE;
    localparam int           N_INSTR    = 3000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  data_i;
    logic [15:0] ptr_i = '0;
    logic        irq_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [15:0] addr_o;
    logic        rd_o, code_o, io_o, sys_o;
    logic [1:0]  phase_o;
    logic [15:0] pc_o;
    logic [7:0]  opcode_o, operand_o;
    logic        operand_valid_o;
    logic [15:0] ret_pc_o;

    logic [7:0]  mem [256];
    int          total = 0;
    int          bad = 0;

    logic [15:0] exp_pc;
    logic [15:0] exp_ret;
    logic        exp_ent;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    always_comb data_i = mem[addr_o[7:0]];

    instr_phase_seq #(
        .ADDR_W     (16),
        .IRQ_VECTOR (VEC)
    ) dut_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .data_i          (data_i),
        .ptr_i           (ptr_i),
        .irq_i           (irq_i),
        .irq_en_i        (irq_en_i),
        .addr_o          (addr_o),
        .rd_o            (rd_o),
        .code_o          (code_o),
        .io_o            (io_o),
        .sys_o           (sys_o),
        .phase_o         (phase_o),
        .pc_o            (pc_o),
        .opcode_o        (opcode_o),
        .operand_o       (operand_o),
        .operand_valid_o (operand_valid_o),
        .ret_pc_o        (ret_pc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // 0 none, 1 operand byte, 2 code load, 3 io load, 4 sys load, 5 plain load
    function automatic int kind_of(input logic [7:0] op);
        if (op[7:6] == 2'b10) return 1;
        if (op == 8'h4C) return 2;
        if (op == 8'h4D) return 3;
        if (op == 8'h4E) return 4;
        if (op == 8'h4F) return 5;
        return 0;
    endfunction

    task automatic noise();
        irq_i    = 1'($urandom);
        irq_en_i = 1'($urandom);
    endtask

    task automatic do_instr(input int idx);
        logic [15:0] faddr;
        logic [15:0] maddr;
        logic [7:0]  op;
        logic [7:0]  mdata;
        logic        entered;
        int          k;
        int          r;
        // fetch phase
        faddr   = exp_ent ? VEC : exp_pc;
        entered = exp_ent;
        ptr_i   = 16'($urandom);
        chk("R1 fetch phase", 32'(phase_o), 32'd3);
        chk("R3 fetch rd/code/io", 32'({rd_o, code_o, io_o}), 32'b110);
        chk("R3 R9 fetch addr", 32'(addr_o), 32'(faddr));
        chk("R9 R10 fetch sys", 32'(sys_o), 32'(exp_ent));
        op = mem[faddr[7:0]];
        if (exp_ent) begin
            exp_ret = exp_pc;
            exp_pc  = VEC;
            exp_ent = 1'b0;
        end
        noise();
        @(negedge clk_i);
        // decode phase
        chk("R1 decode phase", 32'(phase_o), 32'd0);
        chk("R10 decode no rd", 32'({rd_o, code_o, io_o, sys_o}), 32'd0);
        chk("R3 opcode latched", 32'(opcode_o), 32'(op));
        chk("R5 R9 pc", 32'(pc_o), 32'(exp_pc));
        if (entered) chk("R9 ret pc", 32'(ret_pc_o), 32'(exp_ret));
        noise();
        @(negedge clk_i);
        // memory phase
        k = kind_of(op);
        maddr = (k == 1) ? exp_pc + 16'd1 : ptr_i;
        chk("R1 memory phase", 32'(phase_o), 32'd1);
        case (k)
            1: chk("R4 imm read", 32'({rd_o, code_o, io_o, sys_o}), 32'b1100);
            2: chk("R6 code load", 32'({rd_o, code_o, io_o, sys_o}), 32'b1100);
            3: chk("R6 io load", 32'({rd_o, code_o, io_o, sys_o}), 32'b1010);
            4: chk("R7 sys load", 32'({rd_o, code_o, io_o, sys_o}), 32'b1001);
            5: chk("R7 plain load", 32'({rd_o, code_o, io_o, sys_o}), 32'b1000);
            default: chk("R8 no read", 32'({rd_o, code_o, io_o, sys_o}), 32'd0);
        endcase
        if (k != 0) chk("R4 R6 R7 mem addr", 32'(addr_o), 32'(maddr));
        mdata = mem[maddr[7:0]];
        @(negedge clk_i);
        // ALU phase
        if (idx == 7) begin
            irq_i = 1'b1; irq_en_i = 1'b1;
        end else if (idx == 8 || idx == 9) begin
            irq_i = 1'b1; irq_en_i = 1'b0;
        end else begin
            r = int'($urandom % 16);
            irq_i    = (r < 3);
            irq_en_i = (r == 0) || (r >= 6 && r < 10);
        end
        exp_ent = irq_i && irq_en_i;
        chk("R1 alu phase", 32'(phase_o), 32'd2);
        chk("R10 alu no rd", 32'({rd_o, code_o, io_o, sys_o}), 32'd0);
        chk("R8 operand valid", 32'(operand_valid_o), 32'(k != 0));
        if (k != 0) chk("R4 R6 R7 operand", 32'(operand_o), 32'(mdata));
        chk("R5 pc before step", 32'(pc_o), 32'(exp_pc));
        exp_pc = exp_pc + ((k == 1) ? 16'd2 : 16'd1);
        @(negedge clk_i);
        chk("R5 pc after step", 32'(pc_o), 32'(exp_pc));
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", total, N_INSTR);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            r = int'($urandom % 8);
            if (r < 3)       mem[i] = {2'b10, 6'($urandom)};
            else if (r == 3) mem[i] = 8'h4C + 8'($urandom % 4);
            else             mem[i] = 8'($urandom);
        end
        mem[0]  = 8'h85; mem[1]  = 8'hA5;
        mem[2]  = 8'h4C; mem[3]  = 8'h4D;
        mem[4]  = 8'h4E; mem[5]  = 8'h4F;
        mem[6]  = 8'h12; mem[7]  = 8'hBF;
        mem[8]  = 8'h3C; mem[9]  = 8'hC0;
        mem[10] = 8'h40; mem[11] = 8'h7F;
        mem[254] = 8'h9A; mem[255] = 8'h5B;
        exp_pc  = 16'h0000;
        exp_ret = 16'h0000;
        exp_ent = 1'b0;
        repeat (3) @(posedge clk_i);
        // R2: state held in reset
        chk("R2 reset phase", 32'(phase_o), 32'd3);
        chk("R2 reset pc", 32'(pc_o), 32'd0);
        chk("R2 reset sys", 32'(sys_o), 32'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        chk("R2 first fetch addr", 32'(addr_o), 32'd0);
        chk("R2 first fetch sys", 32'(sys_o), 32'd0);
        for (int n = 0; n < N_INSTR; n++) begin
            do_instr(n);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule